// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a register-mapped watchdog timer with 32-bit registers. An up-counter advances on a slow tick that a tick-enable input supplies, optionally divided by a power-of-two prescaler. When the counter steps past all-ones it is refilled from the load register and a reset-request output is raised for a fixed number of system clocks. The counter keeps running after that. Software keeps the system alive by writing a trigger register with a value different from the one it holds. That write copies the load value into the counter.

Counting is switched on and off only by a two-word key sequence written to the key register. Every register write is posted: the written word waits in a per-register staging slot for two slow ticks before it takes effect. While it waits, a bit in the pending-status register reads 1, and software polls that register before relying on a write.

The key state machine has four states. STOPPED moves to STOP_ARMED on the word 0xBBBB. STOP_ARMED moves to RUNNING on 0x4444, stays in STOP_ARMED on a repeated 0xBBBB, and returns to STOPPED on any other word. RUNNING moves to RUN_ARMED on 0xAAAA. RUN_ARMED moves to STOPPED on 0x5555, stays in RUN_ARMED on a repeated 0xAAAA, and returns to RUNNING on any other word. These transitions are taken only when a posted key write commits.

Top module: `wdog_keyed_timer`

## Requirements
- R1: After reset the timer is stopped, the control, counter, load and trigger registers read zero, the pending-status register reads zero and rst_req is low.
- R2: Offset 0x00 reads the revision with major in bits 7:4 and minor in bits 3:0 (default 0x31). Unmapped offsets read zero.
- R3: A write to control (0x24), counter (0x28), load (0x2C), trigger (0x30) or key (0x48) sets pending-status (0x34) bit 0, 1, 2, 3 or 4 respectively from the next clock. The write takes effect, and the bit clears, at the edge that samples the second tick_en pulse after the write. A new write to the same register restarts that wait.
- R4: A committed key word 0xBBBB followed by a committed 0x4444 starts counting.
- R5: Any other pairing, such as 0xBBBB followed by 0x5555, leaves a stopped timer stopped with the counter unchanged.
- R6: Committed key words 0xAAAA then 0x5555 stop counting. A stopped counter holds its value.
- R7: A committed trigger value that differs from the trigger register's current contents copies the load register into the counter.
- R8: A committed trigger value equal to the current contents does not reload the counter.
- R9: When the counter is all-ones and a count tick arrives, it is refilled from the load register and counting continues.
- R10: Each overflow drives rst_req high for exactly RST_CYCLES (default 4) consecutive system clocks, starting the clock after the overflow edge.
- R11: Control bit 5 enables the prescaler and bits 4:2 give the exponent k. The counter then advances once per 2^k ticks. Only bits 5:2 of control are stored.
- R12: Writing 0xFFFFFF80 directly to the counter while running causes an overflow 128 ticks after the write commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock pulse marking a slow functional-clock tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| rst_req | output | 1 | Reset request pulse |

## Verification
A posted write shows its pending bit one clock after the write edge. Its value becomes visible, and its side effects occur, on the clock after the edge that samples the second following tick_en pulse. The rst_req output rises on the clock after the overflow edge. The bench models these latencies with a behavioural reference that advances on the same clock edge as the design. It compares rdata and rst_req at every falling edge, when both are settled. The directed checks poll the pending-status register before reading any result, so they never depend on a guessed latency.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int NUM_SLOTS = 5;
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_CNT  = 1;
    localparam int SLOT_LOAD = 2;
    localparam int SLOT_TRIG = 3;
    localparam int SLOT_KEY  = 4;

    localparam logic [7:0] OFS_ID     = 8'h00;
    localparam logic [7:0] OFS_CTRL   = 8'h24;
    localparam logic [7:0] OFS_CNT    = 8'h28;
    localparam logic [7:0] OFS_LOAD   = 8'h2C;
    localparam logic [7:0] OFS_TRIG   = 8'h30;
    localparam logic [7:0] OFS_STATUS = 8'h34;
    localparam logic [7:0] OFS_KEY    = 8'h48;

    localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
    localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;
    localparam logic [31:0] KEY_HALT_A = 32'h0000_AAAA;
    localparam logic [31:0] KEY_HALT_B = 32'h0000_5555;

    localparam logic [31:0] CTRL_MASK = 32'h0000_003C;

    typedef enum logic [1:0] {
        KS_STOPPED,
        KS_STOP_ARMED,
        KS_RUNNING,
        KS_RUN_ARMED
    } key_state_e;

    function automatic logic [7:0] slot_offset(input int idx);
        logic [7:0] ofs;
        unique case (idx)
            SLOT_CTRL: ofs = OFS_CTRL;
            SLOT_CNT:  ofs = OFS_CNT;
            SLOT_LOAD: ofs = OFS_LOAD;
            SLOT_TRIG: ofs = OFS_TRIG;
            default:   ofs = OFS_KEY;
        endcase
        return ofs;
    endfunction

endpackage

// File: rtl/wdt_post_slot.sv
// One posted-write staging slot: holds a written word until LATENCY ticks pass.
module wdt_post_slot #(
    parameter int DATA_W  = 32,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              pending,
    output logic              commit,
    output logic [DATA_W-1:0] staged
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

    logic [CW-1:0] tick_cnt;

    assign commit = pending && tick_en && (tick_cnt == LAST) && !wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            tick_cnt <= '0;
            staged   <= '0;
        end else if (wr) begin
            pending  <= 1'b1;
            tick_cnt <= '0;
            staged   <= wdata;
        end else if (pending && tick_en) begin
            if (tick_cnt == LAST) begin
                pending  <= 1'b0;
                tick_cnt <= '0;
            end else begin
                tick_cnt <= tick_cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/wdt_key_fsm.sv
// Two-word key sequence state machine deciding the run state.
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_commit,
    input  logic [31:0] key_word,
    output logic        running,
    output key_state_e  state
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (key_commit) begin
            unique case (state_q)
                KS_STOPPED:
                    if (key_word == KEY_RUN_A) state_d = KS_STOP_ARMED;
                KS_STOP_ARMED:
                    if (key_word == KEY_RUN_B)      state_d = KS_RUNNING;
                    else if (key_word != KEY_RUN_A) state_d = KS_STOPPED;
                KS_RUNNING:
                    if (key_word == KEY_HALT_A) state_d = KS_RUN_ARMED;
                KS_RUN_ARMED:
                    if (key_word == KEY_HALT_B)      state_d = KS_STOPPED;
                    else if (key_word != KEY_HALT_A) state_d = KS_RUNNING;
            endcase
        end
    end

    always_comb begin
        state   = state_q;
        running = (state_q == KS_RUNNING) || (state_q == KS_RUN_ARMED);
    end
endmodule

// File: rtl/wdt_prescaler.sv
// Divides the tick by 2^exp when enabled; produces count ticks while running.
module wdt_prescaler #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             active,
    input  logic             pre_en,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             count_tick
);
    localparam int DIV_W = (1 << EXP_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] limit;

    assign limit      = (DIV_W'(1) << exp_sel) - DIV_W'(1);
    assign count_tick = active && tick_en && (!pre_en || (div_cnt >= limit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          div_cnt <= '0;
        else if (!active)    div_cnt <= '0;
        else if (tick_en) begin
            if (count_tick)  div_cnt <= '0;
            else             div_cnt <= div_cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/wdog_keyed_timer.sv
module wdog_keyed_timer
    import wdt_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          LATENCY    = 2,
    parameter int          RST_CYCLES = 4,
    parameter logic [3:0]  REV_MAJOR  = 4'd3,
    parameter logic [3:0]  REV_MINOR  = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rst_req
);
    localparam int EXP_W = 3;
    localparam int PW    = $clog2(RST_CYCLES + 1);

    logic [NUM_SLOTS-1:0] wr_slot, pend, commit;
    logic [31:0]          staged [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign wr_slot[g] = wr_en && (addr == ADDR_W'(slot_offset(g)));
        wdt_post_slot #(.DATA_W(32), .LATENCY(LATENCY)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .wr      (wr_slot[g]),
            .wdata   (wdata),
            .pending (pend[g]),
            .commit  (commit[g]),
            .staged  (staged[g])
        );
    end

    logic [31:0] ctrl_q, counter_q, load_q, trig_q, key_q;
    logic        running, count_tick, trig_reload, overflow_ev;
    logic [PW-1:0] pulse_q;
    key_state_e  key_state;

    wdt_key_fsm u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_commit (commit[SLOT_KEY]),
        .key_word   (staged[SLOT_KEY]),
        .running    (running),
        .state      (key_state)
    );

    wdt_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .active     (running),
        .pre_en     (ctrl_q[5]),
        .exp_sel    (ctrl_q[4:2]),
        .count_tick (count_tick)
    );

    assign trig_reload = commit[SLOT_TRIG] && (staged[SLOT_TRIG] != trig_q);
    assign overflow_ev = count_tick && (counter_q == '1)
                         && !commit[SLOT_CNT] && !trig_reload;

    // Committed register file.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
            key_q  <= '0;
        end else begin
            if (commit[SLOT_CTRL]) ctrl_q <= staged[SLOT_CTRL] & CTRL_MASK;
            if (commit[SLOT_LOAD]) load_q <= staged[SLOT_LOAD];
            if (commit[SLOT_TRIG]) trig_q <= staged[SLOT_TRIG];
            if (commit[SLOT_KEY])  key_q  <= staged[SLOT_KEY];
        end
    end

    // Counter: direct write, then trigger reload, then counting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 counter_q <= '0;
        else if (commit[SLOT_CNT])  counter_q <= staged[SLOT_CNT];
        else if (trig_reload)       counter_q <= load_q;
        else if (count_tick) begin
            if (counter_q == '1)    counter_q <= load_q;
            else                    counter_q <= counter_q + 32'd1;
        end
    end

    // Reset-request pulse stretcher.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pulse_q <= '0;
        else if (overflow_ev)    pulse_q <= PW'(RST_CYCLES);
        else if (pulse_q != '0)  pulse_q <= pulse_q - PW'(1);
    end

    assign rst_req = (pulse_q != '0);

    always_comb begin
        rdata = '0;
        unique case (8'(addr))
            OFS_ID:     rdata = {24'd0, REV_MAJOR, REV_MINOR};
            OFS_CTRL:   rdata = ctrl_q;
            OFS_CNT:    rdata = counter_q;
            OFS_LOAD:   rdata = load_q;
            OFS_TRIG:   rdata = trig_q;
            OFS_STATUS: rdata = {{(32-NUM_SLOTS){1'b0}}, pend};
            OFS_KEY:    rdata = key_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic [4:0]  pend,
    input logic [31:0] counter,
    input logic [31:0] load,
    input logic        running,
    input logic        cnt_commit,
    input logic        trig_reload,
    input logic        overflow_ev,
    input logic        rst_req,
    input logic        key_commit,
    input logic [31:0] key_word
);
    for (genvar i = 0; i < 5; i++) begin : g_pend
        assert_pending_waits_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[i]) |-> $past(tick_en));
    end

    assert_start_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(key_commit && key_word == 32'h0000_4444));

    assert_stopped_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_commit && !trig_reload) |=> $stable(counter));

    assert_trigger_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_reload && !cnt_commit) |=> (counter == $past(load)));

    assert_overflow_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_ev |=> (counter == $past(load)));

    assert_overflow_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_ev |=> rst_req);

    assert_request_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(overflow_ev));
endmodule

bind wdog_keyed_timer wdt_checker u_wdt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .pend        (pend),
    .counter     (counter_q),
    .load        (load_q),
    .running     (running),
    .cnt_commit  (commit[1]),
    .trig_reload (trig_reload),
    .overflow_ev (overflow_ev),
    .rst_req     (rst_req),
    .key_commit  (commit[4]),
    .key_word    (staged[4])
);

// File: tb/tb_wdog_keyed_timer.sv
`timescale 1ns/1ps
module tb_wdog_keyed_timer;
    localparam int TICK_P = 4;
    localparam int RSTC   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    wdog_keyed_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    // Tick generator: one pulse every TICK_P clocks.
    int tdiv = 0;
    always @(posedge clk) begin
        #2;
        if (!rst_n) begin tdiv = 0; tick_en = 0; end
        else begin tdiv = (tdiv + 1) % TICK_P; tick_en = (tdiv == 0); end
    end

    // ---------------- behavioural reference ----------------
    bit          m_pend [5] = '{default:0};
    int          m_cnt  [5] = '{default:0};
    logic [31:0] m_stage[5] = '{default:0};
    logic [31:0] m_ctrl = 0, m_counter = 0, m_load = 0, m_trig = 0, m_key = 0;
    bit          m_run = 0;
    int          m_arm = 0;   // 0 none, 1 start half seen, 2 stop half seen
    int          m_div = 0;
    int          m_pulse = 0;

    function automatic int slot_of(logic [7:0] a);
        case (a)
            8'h24: return 0;
            8'h28: return 1;
            8'h2C: return 2;
            8'h30: return 3;
            8'h48: return 4;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin m_pend[i] = 0; m_cnt[i] = 0; m_stage[i] = 0; end
            m_ctrl = 0; m_counter = 0; m_load = 0; m_trig = 0; m_key = 0;
            m_run = 0; m_arm = 0; m_div = 0; m_pulse = 0;
        end else begin
            int w;
            bit cm[5];
            bit ct, reload, ovf;
            logic [31:0] v;
            w = wr_en ? slot_of(addr) : -1;
            for (int i = 0; i < 5; i++)
                cm[i] = m_pend[i] && tick_en && (m_cnt[i] == 1) && (w != i);
            ct = 0;
            if (m_run && tick_en) begin
                if (m_ctrl[5]) ct = (m_div >= ((1 << m_ctrl[4:2]) - 1));
                else ct = 1;
            end
            if (!m_run) m_div = 0;
            else if (tick_en) m_div = ct ? 0 : m_div + 1;
            reload = cm[3] && (m_stage[3] != m_trig);
            ovf = 0;
            if (cm[1]) m_counter = m_stage[1];
            else if (reload) m_counter = m_load;
            else if (ct) begin
                if (m_counter == 32'hFFFF_FFFF) begin m_counter = m_load; ovf = 1; end
                else m_counter = m_counter + 1;
            end
            if (ovf) m_pulse = RSTC;
            else if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (cm[4]) begin
                v = m_stage[4];
                if (!m_run) begin
                    if (v == 32'hBBBB) m_arm = 1;
                    else if (m_arm == 1 && v == 32'h4444) begin m_run = 1; m_arm = 0; end
                    else m_arm = 0;
                end else begin
                    if (v == 32'hAAAA) m_arm = 2;
                    else if (m_arm == 2 && v == 32'h5555) begin m_run = 0; m_arm = 0; end
                    else m_arm = 0;
                end
                m_key = v;
            end
            if (cm[0]) m_ctrl = m_stage[0] & 32'h3C;
            if (cm[2]) m_load = m_stage[2];
            if (cm[3]) m_trig = m_stage[3];
            for (int i = 0; i < 5; i++) begin
                if (w == i) begin m_pend[i] = 1; m_cnt[i] = 0; m_stage[i] = wdata; end
                else if (m_pend[i] && tick_en) begin
                    if (m_cnt[i] == 1) begin m_pend[i] = 0; m_cnt[i] = 0; end
                    else m_cnt[i] = m_cnt[i] + 1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rdata(logic [7:0] a);
        case (a)
            8'h00: return 32'h31;
            8'h24: return m_ctrl;
            8'h28: return m_counter;
            8'h2C: return m_load;
            8'h30: return m_trig;
            8'h34: return {27'd0, m_pend[4], m_pend[3], m_pend[2], m_pend[1], m_pend[0]};
            8'h48: return m_key;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h24: return "R11";
            8'h28: return "R9";
            8'h2C: return "R3";
            8'h30: return "R7";
            8'h34: return "R3";
            8'h48: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the reference, on the falling edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            check(tag_of(addr), rdata, exp_rdata(addr));
            check("R10", {31'd0, rst_req}, {31'd0, m_pulse != 0});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 0;
    endtask

    task automatic read_reg(logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            read_reg(8'h34, s);
            if (s == 0) break;
        end
    endtask

    task automatic write_posted(logic [7:0] a, logic [31:0] d);
        bus_write(a, d);
        wait_idle();
    endtask

    task automatic wait_ticks(int n);
        repeat (n * TICK_P) @(posedge clk);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v, c0, c1;
        int hi, cyc;
        repeat (5) @(posedge clk);
        #2 rst_n = 1;
        cmp_on = 1;

        // R1: reset state
        read_reg(8'h24, v); check("R1", v, 32'h0);
        read_reg(8'h28, v); check("R1", v, 32'h0);
        read_reg(8'h2C, v); check("R1", v, 32'h0);
        read_reg(8'h30, v); check("R1", v, 32'h0);
        read_reg(8'h34, v); check("R1", v, 32'h0);
        check("R1", {31'd0, rst_req}, 32'h0);
        // R2: identification and unmapped offset
        read_reg(8'h00, v); check("R2", v, 32'h31);
        read_reg(8'h10, v); check("R2", v, 32'h0);

        // R3: posted load write shows pending bit 2 on the next clock
        bus_write(8'h2C, 32'h0000_1000);
        @(negedge clk); addr = 8'h34;
        @(negedge clk); check("R3", rdata, 32'h4);
        wait_idle();
        read_reg(8'h2C, v); check("R3", v, 32'h0000_1000);

        // R5: wrong pairing keeps the timer stopped
        write_posted(8'h48, 32'hBBBB);
        write_posted(8'h48, 32'h5555);
        wait_ticks(10);
        read_reg(8'h28, v); check("R5", v, 32'h0);

        // R4: proper start sequence
        write_posted(8'h48, 32'hBBBB);
        write_posted(8'h48, 32'h4444);
        wait_ticks(5);
        read_reg(8'h28, v); check("R4", {31'd0, v != 0}, 32'h1);

        // R7: new trigger value reloads
        write_posted(8'h30, 32'h1);
        read_reg(8'h28, c0);
        check("R7", {31'd0, (c0 >= 32'h1000) && (c0 < 32'h1004)}, 32'h1);
        wait_ticks(4);
        // R8: same trigger value does not reload
        write_posted(8'h30, 32'h1);
        read_reg(8'h28, c1);
        check("R8", {31'd0, c1 >= c0 + 32'd6}, 32'h1);

        // R9, R10: overflow refill and pulse width
        write_posted(8'h2C, 32'hFFFF_FFF0);
        write_posted(8'h30, 32'h2);
        cyc = 0;
        while (!rst_req && cyc < 400) begin @(negedge clk); cyc++; end
        check("R10", {31'd0, rst_req}, 32'h1);
        hi = 0;
        while (rst_req && hi < 50) begin @(negedge clk); hi++; end
        check("R10", hi, RSTC);
        read_reg(8'h28, v);
        check("R9", {31'd0, v >= 32'hFFFF_FFF0}, 32'h1);
        wait_ticks(3);
        read_reg(8'h28, c1);
        check("R9", {31'd0, c1 != v}, 32'h1);

        // R11: prescaler divide by 4
        write_posted(8'h2C, 32'h0000_1000);
        write_posted(8'h30, 32'h3);
        write_posted(8'h24, 32'hFFFF_FFE8);
        read_reg(8'h24, v); check("R11", v, 32'h28);
        read_reg(8'h28, c0);
        wait_ticks(32);
        read_reg(8'h28, c1);
        check("R11", {31'd0, (c1 - c0 >= 7) && (c1 - c0 <= 9)}, 32'h1);

        // R12: direct counter write forces an overflow after 128 ticks
        write_posted(8'h24, 32'h0);
        write_posted(8'h28, 32'hFFFF_FF80);
        cyc = 0;
        while (!rst_req && cyc < 1000) begin @(negedge clk); cyc++; end
        check("R12", {31'd0, (cyc >= 500) && (cyc <= 520)}, 32'h1);

        // R6: stop sequence freezes the counter
        write_posted(8'h48, 32'hAAAA);
        write_posted(8'h48, 32'h5555);
        read_reg(8'h28, c0);
        wait_ticks(10);
        read_reg(8'h28, c1);
        check("R6", c1, c0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule